// File: doc/BRIEF.md
# TDM frame pulse and clock generator

This block derives a time-division-multiplexed bit clock and an 8 kHz frame pulse from one fast reference clock of 65.536 MHz. A free-running 13-bit frame counter divides the reference into 125 µs frames of 8192 cycles. The frame boundary is the cycle in which the counter reads zero. The output clock comes from a counter tap and runs at one of four binary rates. The frame pulse is always exactly one output-clock period wide.

A single 16-bit control word sets the behaviour. It is loaded through a write-only address/data port. The word holds a 2-bit rate code, a clock inversion bit, a pulse polarity bit and a pulse placement bit. The pulse can either straddle the boundary or begin at it. A new word is written at any time but becomes active only at a fixed point 16 reference cycles before the next boundary. All clock phases are aligned at that point and no pulse is in progress, so the whole pulse and the boundary edge of the next frame always come from one consistent setting.

Both outputs are registered, so they carry no decode glitches.

Top module: `tfg_frame_gen`

## Requirements
- R1: The frame counter resets to 0, then advances by one each reference cycle and wraps after 8191. The frame boundary is counter value 0, so it recurs every 8192 cycles, and the first post-reset boundary is the cycle in which reset is released.
- R2: Control bits 13:12 choose the output clock period in reference cycles: code 00 gives 16, 01 gives 8, 10 gives 4 and 11 gives 2. The duty cycle is 50 %, and the clock changes level only at counter values that are multiples of half a period.
- R3: With control bit 11 at 0, `ck_o` is high at counter 8191 and low at counter 0, which is a falling edge at the boundary. With bit 11 at 1, the levels are inverted, which is a rising edge.
- R4: The frame pulse appears once per frame and is asserted for exactly one output-clock period: 16, 8, 4 or 2 cycles for rate codes 00 to 11.
- R5: With control bit 10 at 0, the pulse is active low. With bit 10 at 1, it is active high.
- R6: Let P be the period. With control bit 9 at 0, the pulse is asserted from counter 8192−P/2 through counter P/2−1, straddling the wrap. With bit 9 at 1, it is asserted at counter values 0 to P−1.
- R7: The control word is written when `wr_en` is 1 and `wr_addr` equals the parameter `CTRL_ADDR` (default 0x10). A write with `wr_en` at 0, or to any other address, has no effect on the outputs.
- R8: A written word takes effect from counter value 8176 onward. Up to and including counter 8175, the outputs follow the previous word.
- R9: While reset is asserted, `ck_o` and `fp_o` are both 0. Reset clears the control word to 0x0000, which selects period 16, a falling boundary edge, an active-low pulse and the straddling placement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 65.536 MHz reference clock |
| rst | input | 1 | synchronous active-high reset |
| wr_en | input | 1 | write strobe for the control word |
| wr_addr | input | ADDR_W (8) | write address |
| wr_data | input | 16 | control word data |
| ck_o | output | 1 | TDM output clock |
| fp_o | output | 1 | frame pulse |

## Verification
The assertions assume that a control write never lands on the cycle in which the counter is about to reach 8176. In that cycle the pending word is copied into the active setting, and the bench avoids it by writing only at counter 4000. The assertions also assume reset is held for at least one edge. The width assertion starts counting only on a pulse that began after reset, because the first post-reset pulse is cut by the release point. The stimulus visits every rate code with each of the three flag bits both set and clear, and compares every output cycle against a model computed from the requirements.

// File: rtl/tfg_pkg.sv
`timescale 1ns/1ps
package tfg_pkg;

    // Control word layout
    localparam int unsigned CTRL_W       = 16;
    localparam int unsigned RATE_LSB     = 12;
    localparam int unsigned CLK_INV_BIT  = 11;
    localparam int unsigned FP_HIGH_BIT  = 10;
    localparam int unsigned FP_EDGE_BIT  = 9;

    // Output clock rates: slowest period is 2**MAX_PER_LOG2 reference cycles
    localparam int unsigned NUM_RATES    = 4;
    localparam int unsigned MAX_PER_LOG2 = 4;
    localparam int unsigned MAX_PERIOD   = 1 << MAX_PER_LOG2;

    typedef enum logic [1:0] {
        RATE_DIV16 = 2'd0,
        RATE_DIV8  = 2'd1,
        RATE_DIV4  = 2'd2,
        RATE_DIV2  = 2'd3
    } rate_e;

    typedef struct packed {
        rate_e rate;
        logic  clk_inv;     // 1: rising edge at boundary
        logic  fp_high;     // 1: pulse active high
        logic  fp_at_edge;  // 1: pulse starts at boundary
    } tfg_cfg_t;

    function automatic tfg_cfg_t decode_ctrl(input logic [CTRL_W-1:0] w);
        tfg_cfg_t c;
        c.rate       = rate_e'(w[RATE_LSB +: 2]);
        c.clk_inv    = w[CLK_INV_BIT];
        c.fp_high    = w[FP_HIGH_BIT];
        c.fp_at_edge = w[FP_EDGE_BIT];
        return c;
    endfunction

    function automatic int unsigned period_of(input rate_e r);
        return MAX_PERIOD >> int'(r);
    endfunction

endpackage

// File: rtl/tfg_frame_cnt.sv
`timescale 1ns/1ps
module tfg_frame_cnt #(
    parameter int unsigned FRAME_LEN = 8192,
    parameter int unsigned LOAD_AT   = 8176,
    localparam int unsigned CNT_W    = $clog2(FRAME_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic             load_nxt
);

    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        if (cnt_q == CNT_W'(FRAME_LEN - 1)) begin
            cnt_nxt = '0;
        end else begin
            cnt_nxt = cnt_q + 1'b1;
        end
        load_nxt = (cnt_nxt == CNT_W'(LOAD_AT));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_nxt;
        end
    end

endmodule

// File: rtl/tfg_ctrl_reg.sv
`timescale 1ns/1ps
module tfg_ctrl_reg
    import tfg_pkg::*;
#(
    parameter int unsigned        ADDR_W    = 8,
    parameter logic [ADDR_W-1:0]  CTRL_ADDR = 8'h10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              load_nxt,
    output tfg_cfg_t          cfg_nxt
);

    logic [CTRL_W-1:0] ctrl_q;   // pending word, as written
    tfg_cfg_t          cfg_q;    // active settings
    logic              hit;

    assign hit = wr_en && (wr_addr == CTRL_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (hit) begin
            ctrl_q <= wr_data;
        end
    end

    // The pending word only becomes active at the load point ahead of a boundary
    always_comb begin
        if (load_nxt) begin
            cfg_nxt = decode_ctrl(ctrl_q);
        end else begin
            cfg_nxt = cfg_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_nxt;
        end
    end

endmodule

// File: rtl/tfg_shaper.sv
`timescale 1ns/1ps
module tfg_shaper
    import tfg_pkg::*;
#(
    parameter int unsigned FRAME_LEN = 8192,
    localparam int unsigned CNT_W    = $clog2(FRAME_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt_nxt,
    input  tfg_cfg_t         cfg_nxt,
    output logic             ck_o,
    output logic             fp_o
);

    // Output levels at counter 0 with the all-zero setting:
    // clock tap low, pulse window open and active low.
    localparam logic CK_RST = 1'b0;
    localparam logic FP_RST = 1'b0;

    logic [NUM_RATES-1:0] tap;      // raw clock for each rate
    logic [NUM_RATES-1:0] win_mid;  // straddling pulse window
    logic [NUM_RATES-1:0] win_lead; // pulse window starting at boundary

    for (genvar r = 0; r < NUM_RATES; r++) begin : g_rate
        localparam int unsigned PER  = MAX_PERIOD >> r;
        localparam int unsigned HALF = PER / 2;
        assign tap[r]      = cnt_nxt[MAX_PER_LOG2 - 1 - r];
        assign win_mid[r]  = (cnt_nxt >= CNT_W'(FRAME_LEN - HALF)) ||
                             (cnt_nxt <  CNT_W'(HALF));
        assign win_lead[r] = (cnt_nxt <  CNT_W'(PER));
    end

    logic ck_d;
    logic win;
    logic fp_d;

    always_comb begin
        ck_d = tap[cfg_nxt.rate] ^ cfg_nxt.clk_inv;
        win  = cfg_nxt.fp_at_edge ? win_lead[cfg_nxt.rate] : win_mid[cfg_nxt.rate];
        fp_d = cfg_nxt.fp_high ? win : ~win;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ck_o <= CK_RST;
            fp_o <= FP_RST;
        end else begin
            ck_o <= ck_d;
            fp_o <= fp_d;
        end
    end

endmodule

// File: rtl/tfg_frame_gen.sv
`timescale 1ns/1ps
module tfg_frame_gen
    import tfg_pkg::*;
#(
    parameter int unsigned       FRAME_LEN = 8192,
    parameter int unsigned       ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CTRL_W-1:0] wr_data,
    output logic              ck_o,
    output logic              fp_o
);

    localparam int unsigned CNT_W   = $clog2(FRAME_LEN);
    localparam int unsigned LOAD_AT = FRAME_LEN - MAX_PERIOD;

    logic [CNT_W-1:0] cnt_nxt;
    logic             load_nxt;
    tfg_cfg_t         cfg_nxt;

    tfg_frame_cnt #(
        .FRAME_LEN (FRAME_LEN),
        .LOAD_AT   (LOAD_AT)
    ) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .cnt_nxt  (cnt_nxt),
        .load_nxt (load_nxt)
    );

    tfg_ctrl_reg #(
        .ADDR_W    (ADDR_W),
        .CTRL_ADDR (CTRL_ADDR)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .load_nxt (load_nxt),
        .cfg_nxt  (cfg_nxt)
    );

    tfg_shaper #(
        .FRAME_LEN (FRAME_LEN)
    ) u_shape (
        .clk     (clk),
        .rst     (rst),
        .cnt_nxt (cnt_nxt),
        .cfg_nxt (cfg_nxt),
        .ck_o    (ck_o),
        .fp_o    (fp_o)
    );

endmodule

// File: rtl/tfg_frame_gen_chk.sv
`timescale 1ns/1ps
module tfg_frame_gen_chk
    import tfg_pkg::*;
#(
    parameter int unsigned FRAME_LEN = 8192,
    localparam int unsigned CNT_W    = $clog2(FRAME_LEN),
    localparam int unsigned LOAD_AT  = FRAME_LEN - MAX_PERIOD
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] cnt_nxt,
    input tfg_cfg_t         cfg_nxt,
    input logic             ck_o,
    input logic             fp_o
);

    logic [CNT_W-1:0] cnt_v;     // counter value matching the outputs
    tfg_cfg_t         cfg_v;     // settings matching the outputs
    logic             run_q;     // at least one edge since reset release
    logic             prev_act;
    logic             armed;     // a pulse began after reset
    logic [7:0]       streak;
    logic             rst_d;
    logic             fp_act;
    logic [CNT_W-1:0] half_mask;
    logic [CNT_W-1:0] per_v;

    assign fp_act    = (fp_o == cfg_v.fp_high);
    assign per_v     = CNT_W'(period_of(cfg_v.rate));
    assign half_mask = CNT_W'(period_of(cfg_v.rate) / 2 - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_v    <= '0;
            cfg_v    <= '0;
            run_q    <= 1'b0;
            prev_act <= 1'b1;
            armed    <= 1'b0;
            streak   <= '0;
        end else begin
            cnt_v    <= cnt_nxt;
            cfg_v    <= cfg_nxt;
            run_q    <= 1'b1;
            prev_act <= fp_act;
            if (fp_act && !prev_act) armed <= 1'b1;
            streak   <= fp_act ? streak + 8'd1 : 8'd0;
        end
    end

    // R9: outputs held low during reset
    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst_d) begin
            assert_reset_levels_R9: assert (ck_o == 1'b0 && fp_o == 1'b0)
                else $error("reset output levels wrong");
        end
    end

    // R2: clock changes level only on half-period multiples
    assert_clk_grid_R2: assert property (@(posedge clk) disable iff (rst)
        (run_q && ck_o != $past(ck_o)) |-> ((cnt_v & half_mask) == '0));

    // R3: boundary edge direction follows the inversion bit
    assert_boundary_edge_R3: assert property (@(posedge clk) disable iff (rst)
        (run_q && cnt_v == '0) |-> (ck_o == cfg_v.clk_inv && $past(ck_o) != ck_o));

    // R4: every complete pulse lasts one clock period
    assert_pulse_width_R4: assert property (@(posedge clk) disable iff (rst)
        (armed && prev_act && !fp_act) |-> (streak == 8'(per_v)));

    // R6: pulse is active at the boundary in either placement
    assert_pulse_at_boundary_R6: assert property (@(posedge clk) disable iff (rst)
        (run_q && cnt_v == '0) |-> fp_act);

    // R6: leading placement has ended one period after the boundary
    assert_lead_end_R6: assert property (@(posedge clk) disable iff (rst)
        (run_q && cfg_v.fp_at_edge && cnt_v == per_v) |-> !fp_act);

    // R8: settings move only at the load point
    assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (run_q && cnt_v != CNT_W'(LOAD_AT)) |-> $stable(cfg_v));

endmodule

bind tfg_frame_gen tfg_frame_gen_chk #(
    .FRAME_LEN (FRAME_LEN)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cnt_nxt (cnt_nxt),
    .cfg_nxt (cfg_nxt),
    .ck_o    (ck_o),
    .fp_o    (fp_o)
);

// File: tb/test_tfg_frame_gen.sv
`timescale 1ns/1ps
module test_tfg_frame_gen;

    localparam int FRAME   = 8192;
    localparam int LOAD_AT = FRAME - 16;
    localparam logic [7:0] CTRL_ADDR = 8'h10;

    // {control word, expected pulse width, first active counter value from 8176}
    localparam logic [36:0] VEC [16] = '{
        {16'h0000, 8'd16, 13'd8184}, {16'h1000, 8'd8, 13'd8188},
        {16'h2000, 8'd4,  13'd8190}, {16'h3000, 8'd2, 13'd8191},
        {16'h0E00, 8'd16, 13'd0},    {16'h1E00, 8'd8, 13'd0},
        {16'h2E00, 8'd4,  13'd0},    {16'h3E00, 8'd2, 13'd0},
        {16'h0A00, 8'd16, 13'd0},    {16'h1A00, 8'd8, 13'd0},
        {16'h2A00, 8'd4,  13'd0},    {16'h3A00, 8'd2, 13'd0},
        {16'h0400, 8'd16, 13'd8184}, {16'h1400, 8'd8, 13'd8188},
        {16'h2400, 8'd4,  13'd8190}, {16'h3400, 8'd2, 13'd8191}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        ck_o;
    logic        fp_o;

    always #2 clk = ~clk;

    tfg_frame_gen i_tfg_frame_gen (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ck_o    (ck_o),
        .fp_o    (fp_o)
    );

    int          n_chk = 0;
    int          n_fail = 0;
    int          bcnt = 0;
    logic [15:0] sh_m = '0;
    logic [15:0] act_m = '0;
    bit          done = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Expected outputs at counter b under control word w
    function automatic void model(input int b, input logic [15:0] w,
                                  output logic eck, output logic efp);
        int  per;
        bit  act;
        per = 16 >> w[13:12];
        eck = ((b % per) >= per / 2) ^ w[11];
        if (w[9]) act = (b < per);
        else      act = (b >= FRAME - per / 2) || (b < per / 2);
        efp = act ? w[10] : ~w[10];
    endfunction

    // One reference cycle; called and returning at a falling edge
    task automatic tick(input logic we, input logic [7:0] a, input logic [15:0] d);
        int nb;
        wr_en = we; wr_addr = a; wr_data = d;
        @(posedge clk);
        nb = (bcnt + 1) % FRAME;
        if (nb == LOAD_AT) act_m = sh_m;
        if (we && a == CTRL_ADDR) sh_m = d;
        bcnt = nb;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog R1: actual %0d expected %0d", 0, 1);
            summary();
            $finish;
        end
    end

    task automatic observe_frame(input int i);
        logic [15:0] w;
        int wexp, sexp, mism, width, first, toggles;
        logic eck, efp, prev_ck, ck_pre, ck_at0, fp_at0;
        logic [15:0] nxt;
        w    = VEC[i][36:21];
        wexp = int'(VEC[i][20:13]);
        sexp = int'(VEC[i][12:0]);
        nxt  = (i < 15) ? VEC[i+1][36:21] : 16'h2E00;
        mism = 0; width = 0; first = -1; toggles = 0;
        prev_ck = ck_o; ck_pre = 1'b0; ck_at0 = 1'b0; fp_at0 = 1'b0;
        for (int j = 0; j < FRAME; j++) begin
            model(bcnt, act_m, eck, efp);
            if (ck_o !== eck || fp_o !== efp) mism++;
            if (fp_o == w[10]) begin
                width++;
                if (first < 0) first = bcnt;
            end
            if (j > 0 && ck_o != prev_ck) toggles++;
            prev_ck = ck_o;
            if (bcnt == FRAME - 1) ck_pre = ck_o;
            if (bcnt == 0) begin ck_at0 = ck_o; fp_at0 = fp_o; end
            if (bcnt == 4000) tick(1'b1, CTRL_ADDR, nxt);
            else              tick(1'b0, CTRL_ADDR, 16'h0000);
        end
        // R1 R8 (and R7 for vector 0): every cycle matches the model
        check(mism == 0, "R1 R8 R7", $sformatf("vec %0d cycle mismatches", i), mism, 0);
        check(width == wexp, "R4", $sformatf("vec %0d pulse width", i), width, wexp);
        check(first == sexp, "R6", $sformatf("vec %0d pulse start", i), first, sexp);
        check(ck_pre == ~w[11] && ck_at0 == w[11], "R3",
              $sformatf("vec %0d boundary clock levels", i),
              int'({ck_pre, ck_at0}), int'({~w[11], w[11]}));
        check(fp_at0 == w[10], "R5", $sformatf("vec %0d pulse level at boundary", i),
              int'(fp_at0), int'(w[10]));
        check(toggles == 2 * FRAME / wexp - 1, "R2", $sformatf("vec %0d clock toggles", i),
              toggles, 2 * FRAME / wexp - 1);
    endtask

    initial begin
        logic eck, efp;
        int   mism;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(ck_o == 1'b0, "R9", "ck_o in reset", int'(ck_o), 0);
        check(fp_o == 1'b0, "R9", "fp_o in reset", int'(fp_o), 0);
        rst = 1'b0;
        bcnt = 0; sh_m = '0; act_m = '0;
        model(0, 16'h0000, eck, efp);
        check(ck_o === eck && fp_o === efp, "R1", "first boundary levels",
              int'({ck_o, fp_o}), int'({eck, efp}));

        // Lead-in: ignored writes (R7), then vector 0
        mism = 0;
        while (bcnt != LOAD_AT) begin
            model(bcnt, act_m, eck, efp);
            if (ck_o !== eck || fp_o !== efp) mism++;
            if (bcnt == 100)      tick(1'b1, 8'h11, 16'hFFFF);
            else if (bcnt == 200) tick(1'b0, CTRL_ADDR, 16'h3E00);
            else if (bcnt == 300) tick(1'b1, CTRL_ADDR, VEC[0][36:21]);
            else                  tick(1'b0, CTRL_ADDR, 16'h0000);
        end
        check(mism == 0, "R7", "lead-in mismatches", mism, 0);

        // Table walk across rate codes and flag combinations
        for (int i = 0; i < 16; i++) observe_frame(i);

        // Mid-run reset clears the active and pending settings (R9)
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(ck_o == 1'b0 && fp_o == 1'b0, "R9", "outputs after mid-run reset",
              int'({ck_o, fp_o}), 0);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        bcnt = 0; sh_m = '0; act_m = '0;
        mism = 0;
        for (int j = 0; j < FRAME + 40; j++) begin
            model(bcnt, act_m, eck, efp);
            if (ck_o !== eck || fp_o !== efp) mism++;
            tick(1'b0, CTRL_ADDR, 16'h0000);
        end
        check(mism == 0, "R9", "default settings after reset", mism, 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule